// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synthesizable synchronous static memory with a data word split into byte lanes and an internal two-bit burst counter. Address, enables, strobes, write controls and write data are all captured on the rising clock edge. Read data comes from an output register one clock after the address is captured, so a four-beat burst delivers data on the cycles following the first with no gaps. The output enable is asynchronous and only gates the output-valid flag. The bidirectional data bus is modelled as a separate input bus, output bus and a drive flag.

A cycle is started by one of two address strobes. The CPU strobe counts only while the primary enable is low, and it always begins a read. The controller strobe begins a read or a write, depending on the write controls. Cycles with neither strobe continue the current burst: they step the counter or hold it. Three enables (one primary active-low, one secondary active-low, one secondary active-high) select the part. Any start cycle that sees an inactive enable deselects the part. The next cycle then shows the output in high impedance.

Top module: `burst_sram`

## Requirements
- R1: Lane k (k = 0..3) covers data bits 8k+7:8k. A write is qualified when `wr_all_n_i` is low, which writes every lane, or when `lane_wr_en_n_i` is low and at least one bit of `lane_sel_n_i` is low, which writes the lanes whose bits are low. While `lane_wr_en_n_i` is high, `lane_sel_n_i` has no effect and the cycle is a read.
- R2: While `en_a_n_i` is high, `start_cpu_n_i` is ignored. The cycle is then decoded as if that strobe were high.
- R3: `start_cpu_n_i` low with all three enables active loads `addr_i` and starts a read, even when the write qualifier is asserted.
- R4: `start_cpu_n_i` low with `en_a_n_i` low, but `en_b_n_i` high or `en_c_i` low, deselects. No access is made, and later cycles without a strobe make none.
- R5: `start_ctl_n_i` low (with the CPU strobe high or ignored) loads `addr_i` and performs a read or a write as the qualifier says. If any enable is inactive, it deselects instead.
- R6: On a selected cycle without a strobe, with `step_n_i` low, the counter steps and the access uses the next burst address. The upper address bits are kept. For the low two bits, beat k from start s is s+k mod 4 when `lin_burst_i` is high, and s xor k when it is low.
- R7: On a selected cycle without a strobe, with `step_n_i` high, the access reuses the current burst address.
- R8: After a CPU-strobe read, a cycle without a strobe and with the write qualifier asserted writes the current burst address.
- R9: A read captured at edge N places the word on `dout_o` and raises `dout_en_o` after edge N+1.
- R10: `dout_en_o` is low whenever `out_en_n_i` is high, and after any edge that retired a write or no access.
- R11: A write changes only its enabled lanes. A read captured on the next edge returns the new data.
- R12: After reset the part is deselected, `dout_en_o` is low, and cycles without a strobe make no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address |
| en_a_n_i | input | 1 | Primary enable, active low, also gates the CPU strobe |
| en_b_n_i | input | 1 | Secondary enable, active low |
| en_c_i | input | 1 | Secondary enable, active high |
| start_cpu_n_i | input | 1 | CPU address strobe, active low, read only |
| start_ctl_n_i | input | 1 | Controller address strobe, active low |
| step_n_i | input | 1 | Burst advance, active low; high holds |
| wr_all_n_i | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n_i | input | 1 | Byte-lane write enable, active low |
| lane_sel_n_i | input | LANES | Per-lane write strobes, active low |
| out_en_n_i | input | 1 | Asynchronous output enable, active low |
| lin_burst_i | input | 1 | 1 = linear burst order, 0 = interleaved |
| din_i | input | LANES*LANE_W | Write data |
| dout_o | output | LANES*LANE_W | Read data from the output register |
| dout_en_o | output | 1 | High when `dout_o` would be driven |

## Verification
The assertions take the inputs as fully known at every edge after reset. They also assume that `lin_burst_i` is a static strap, because the burst order is recomputed from it on every beat. The random stimulus draws every control from $urandom, so all values are defined. It changes the burst order only in the idle cycles between phases, which it ends with a deselect. It fills the whole array with known data before any read, so every compared word is defined.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low two address bits of beat k in a burst starting at 'first'
  function automatic logic [1:0] beat_lo(input logic [1:0] first,
                                         input logic [1:0] k,
                                         input logic lin);
    return lin ? (first + k) : (first ^ k);
  endfunction
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode #(
  parameter int LANES = 4
) (
  input  logic             en_a_n,
  input  logic             en_b_n,
  input  logic             en_c,
  input  logic             cpu_n,
  input  logic             ctl_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             lane_en_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             sel_q,
  output logic             load,
  output logic             drop,
  output logic             access,
  output logic             is_write,
  output logic             advance,
  output logic [LANES-1:0] mask
);
  logic             all_on;
  logic             cpu_go;
  logic [LANES-1:0] raw_mask;
  logic             wq;

  always_comb begin
    all_on   = !en_a_n && !en_b_n && en_c;
    cpu_go   = !cpu_n && !en_a_n;
    raw_mask = !wr_all_n ? '1 : (!lane_en_n ? ~lane_n : '0);
    wq       = |raw_mask;
    load     = 1'b0;
    drop     = 1'b0;
    access   = 1'b0;
    is_write = 1'b0;
    advance  = 1'b0;
    if (cpu_go) begin
      if (all_on) begin
        load   = 1'b1;
        access = 1'b1;
      end else begin
        drop = 1'b1;
      end
    end else if (!ctl_n) begin
      if (all_on) begin
        load     = 1'b1;
        access   = 1'b1;
        is_write = wq;
      end else begin
        drop = 1'b1;
      end
    end else if (sel_q) begin
      access   = 1'b1;
      is_write = wq;
      advance  = !step_n;
    end
    mask = is_write ? raw_mask : '0;
  end
endmodule

// File: rtl/bsram_burst.sv
module bsram_burst
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  input  logic              lin,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_q;
  logic [1:0]      first_q;
  logic [1:0]      cnt_q;
  logic [1:0]      cnt_use;

  always_comb begin
    cnt_use  = advance ? cnt_q + 2'd1 : cnt_q;
    acc_addr = load ? ext_addr : {base_q, beat_lo(first_q, cnt_use, lin)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      first_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      base_q  <= ext_addr[ADDR_W-1:2];
      first_q <= ext_addr[1:0];
      cnt_q   <= '0;
    end else if (advance) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == 2'd0)); // R6
  AST_HOLD_ON_SUSPEND: assert property (@(posedge clk) disable iff (rst)
    (!load && !advance) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/bsram_store.sv
module bsram_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        we,
  input  logic                    re,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (we[l]) mem[addr] <= wdata[l*LANE_W +: LANE_W];
      if (re) q <= mem[addr];
    end
    assign rdata[l*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    en_a_n_i,
  input  logic                    en_b_n_i,
  input  logic                    en_c_i,
  input  logic                    start_cpu_n_i,
  input  logic                    start_ctl_n_i,
  input  logic                    step_n_i,
  input  logic                    wr_all_n_i,
  input  logic                    lane_wr_en_n_i,
  input  logic [LANES-1:0]        lane_sel_n_i,
  input  logic                    out_en_n_i,
  input  logic                    lin_burst_i,
  input  logic [LANES*LANE_W-1:0] din_i,
  output logic [LANES*LANE_W-1:0] dout_o,
  output logic                    dout_en_o
);
  localparam int DW = LANES * LANE_W;

  logic             load, drop, access, is_write, advance;
  logic [LANES-1:0] mask;
  logic [ADDR_W-1:0] acc_addr;

  logic              sel_q;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [DW-1:0]     s1_din;
  logic [LANES-1:0]  s1_mask;
  logic              rd_valid_q;

  bsram_decode #(.LANES(LANES)) u_dec (
    .en_a_n(en_a_n_i), .en_b_n(en_b_n_i), .en_c(en_c_i),
    .cpu_n(start_cpu_n_i), .ctl_n(start_ctl_n_i), .step_n(step_n_i),
    .wr_all_n(wr_all_n_i), .lane_en_n(lane_wr_en_n_i), .lane_n(lane_sel_n_i),
    .sel_q(sel_q), .load(load), .drop(drop), .access(access),
    .is_write(is_write), .advance(advance), .mask(mask)
  );

  bsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst(rst), .load(load), .advance(advance),
    .lin(lin_burst_i), .ext_addr(addr_i), .acc_addr(acc_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= 1'b0;
      s1_op      <= OP_NONE;
      rd_valid_q <= 1'b0;
    end else begin
      if (load) sel_q <= 1'b1;
      else if (drop) sel_q <= 1'b0;
      s1_op      <= access ? (is_write ? OP_WRITE : OP_READ) : OP_NONE;
      rd_valid_q <= (s1_op == OP_READ);
    end
  end

  always_ff @(posedge clk) begin
    s1_addr <= acc_addr;
    s1_din  <= din_i;
    s1_mask <= mask;
  end

  bsram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .addr(s1_addr),
    .we((s1_op == OP_WRITE) ? s1_mask : '0),
    .re(s1_op == OP_READ),
    .wdata(s1_din), .rdata(dout_o)
  );

  assign dout_en_o = rd_valid_q && !out_en_n_i;

  AST_CPU_ALWAYS_READS: assert property (@(posedge clk) disable iff (rst)
    (!start_cpu_n_i && !en_a_n_i && !en_b_n_i && en_c_i) |=> (s1_op == OP_READ)); // R3
  AST_CPU_DESELECT: assert property (@(posedge clk) disable iff (rst)
    (!start_cpu_n_i && !en_a_n_i && (en_b_n_i || !en_c_i)) |=> (s1_op == OP_NONE && !sel_q)); // R4
  AST_CTL_DESELECT: assert property (@(posedge clk) disable iff (rst)
    ((start_cpu_n_i || en_a_n_i) && !start_ctl_n_i && (en_a_n_i || en_b_n_i || !en_c_i))
    |=> (s1_op == OP_NONE && !sel_q)); // R5
  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
    (access && is_write && !wr_all_n_i) |=> (s1_mask == '1)); // R1
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (s1_op == OP_WRITE) |=> !dout_en_o); // R10
  AST_IDLE_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
    (!sel_q && start_ctl_n_i && (start_cpu_n_i || en_a_n_i)) |=> (s1_op == OP_NONE)); // R12
endmodule

// File: tb/burst_sram_test.sv
`timescale 1ns/100ps
module burst_sram_test;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 8;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic en_a_n = 1'b1, en_b_n = 1'b0, en_c = 1'b1;
  logic cpu_n = 1'b1, ctl_n = 1'b1, step_n = 1'b1;
  logic wr_all_n = 1'b1, lane_en_n = 1'b1;
  logic [NL-1:0] lane_n = '1;
  logic oe_n = 1'b0, lin = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
    .clk(clk), .rst(rst), .addr_i(addr), .en_a_n_i(en_a_n), .en_b_n_i(en_b_n),
    .en_c_i(en_c), .start_cpu_n_i(cpu_n), .start_ctl_n_i(ctl_n), .step_n_i(step_n),
    .wr_all_n_i(wr_all_n), .lane_wr_en_n_i(lane_en_n), .lane_sel_n_i(lane_n),
    .out_en_n_i(oe_n), .lin_burst_i(lin), .din_i(din), .dout_o(dout), .dout_en_o(dout_en)
  );

  // reference model state
  logic [DW-1:0] ref_mem [DEPTH];
  bit            m_sel;
  bit [AW-3:0]   m_base;
  bit [1:0]      m_first, m_cnt;
  int            m_op;          // 0 none, 1 read, 2 write
  bit [AW-1:0]   m_addr;
  bit [DW-1:0]   m_din;
  bit [NL-1:0]   m_mask;
  string         m_tag;
  bit            m_after_cpu;
  bit            w_valid;
  bit [AW-1:0]   w_addr;
  bit            exp_valid;
  bit [DW-1:0]   exp_data;
  string         exp_tag;

  function automatic bit [1:0] lo_of(bit [1:0] s, bit [1:0] k, bit l);
    return l ? s + k : s ^ k;
  endfunction

  function automatic bit [NL-1:0] lanes_of();
    if (!wr_all_n) return '1;
    if (!lane_en_n) return ~lane_n;
    return '0;
  endfunction

  task automatic check(input string req, input bit ok, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_sel = 0; m_op = 0; exp_valid = 0; w_valid = 0; m_after_cpu = 0;
    m_cnt = 0; m_tag = "R12"; exp_tag = "R12";
  endtask

  task automatic model_edge();
    bit all_on;
    bit [NL-1:0] lm;
    bit was_cpu_read;
    // retire stage one
    exp_valid = (m_op == 1);
    exp_tag   = m_tag;
    if (m_op == 1) begin
      exp_data = ref_mem[m_addr];
      if (w_valid && w_addr == m_addr) exp_tag = "R11";
    end
    if (m_op == 2) begin
      for (int l = 0; l < NL; l++)
        if (m_mask[l]) ref_mem[m_addr][l*LW +: LW] = m_din[l*LW +: LW];
    end
    w_valid = (m_op == 2);
    w_addr  = m_addr;
    // capture new inputs
    all_on = !en_a_n && !en_b_n && en_c;
    lm = lanes_of();
    was_cpu_read = m_after_cpu;
    m_after_cpu = 0;
    m_din = din;
    m_mask = lm;
    if (!cpu_n && !en_a_n) begin
      if (all_on) begin
        m_sel = 1; {m_base, m_first} = addr; m_cnt = 0;
        m_op = 1; m_addr = addr; m_tag = "R3"; m_after_cpu = 1;
      end else begin
        m_sel = 0; m_op = 0; m_tag = "R4";
      end
    end else if (!ctl_n) begin
      if (all_on) begin
        m_sel = 1; {m_base, m_first} = addr; m_cnt = 0;
        m_addr = addr; m_op = (lm != 0) ? 2 : 1;
        m_tag = (m_op == 2) ? "R1" : "R5";
      end else begin
        m_sel = 0; m_op = 0; m_tag = "R5";
      end
    end else if (m_sel) begin
      if (!step_n) m_cnt = m_cnt + 1;
      m_addr = {m_base, lo_of(m_first, m_cnt, lin)};
      m_op = (lm != 0) ? 2 : 1;
      m_tag = !step_n ? "R6" : "R7";
      if (m_op == 2 && was_cpu_read) m_tag = "R8";
    end else begin
      m_op = 0;
      m_tag = (!cpu_n) ? "R2" : "R12";
    end
    if (m_op != 1 && m_tag != "R2" && m_tag != "R4") m_mask = (m_op == 2) ? lm : '0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #1;
    if (oe_n) begin
      check("R10", dout_en == 1'b0, {31'd0, dout_en}, '0);
    end else begin
      check(exp_valid ? "R9" : "R10", dout_en == exp_valid, {31'd0, dout_en}, {31'd0, exp_valid});
      if (exp_valid) check(exp_tag, dout === exp_data, dout, exp_data);
    end
  endtask

  task automatic quiet();
    @(negedge clk);
    en_a_n = 0; en_b_n = 0; en_c = 1; cpu_n = 1; ctl_n = 1; step_n = 1;
    wr_all_n = 1; lane_en_n = 1; lane_n = '1; oe_n = 0; din = $urandom;
  endtask

  task automatic deselect();
    quiet(); ctl_n = 0; en_c = 0; tick();
  endtask

  task automatic random_cycle();
    int k;
    quiet();
    addr = AW'($urandom);
    k = $urandom % 16;
    if (k < 3) begin
      cpu_n = 0; en_a_n = ($urandom % 4 == 0);
      ctl_n = ($urandom % 3 != 0);
    end else if (k < 7) begin
      ctl_n = 0;
    end
    if ($urandom % 7 == 0) en_b_n = 1;
    if ($urandom % 7 == 0) en_c = 0;
    step_n = $urandom % 3 == 0;
    if ($urandom % 10 < 4) begin
      if ($urandom % 2 == 0) wr_all_n = 0;
      else begin lane_en_n = 0; lane_n = NL'($urandom); end
    end else begin
      lane_en_n = $urandom % 2;
      lane_n = lane_en_n ? NL'($urandom) : '1;
    end
    oe_n = ($urandom % 6 == 0);
    tick();
  endtask

  initial begin
    void'($urandom(32'd20250611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #0;
    check("R12", dout_en == 1'b0, {31'd0, dout_en}, '0);
    for (int i = 0; i < 4; i++) begin quiet(); step_n = 0; tick(); end  // R12 idle

    // fill every word with global writes through the controller strobe (R5, R1)
    for (int a = 0; a < DEPTH; a++) begin
      quiet(); ctl_n = 0; addr = AW'(a); wr_all_n = 0; din = {a[7:0], 8'hA5, ~a[7:0], 8'h3C};
      tick();
    end

    // CPU strobe with write controls: still a read (R3), then wait-cycle write (R8)
    quiet(); cpu_n = 0; addr = 6'd5; wr_all_n = 0; tick();
    quiet(); lane_en_n = 0; lane_n = 4'b1010; din = 32'h11223344; tick();
    quiet(); ctl_n = 0; addr = 6'd5; tick();
    quiet(); tick();
    quiet(); tick();
    // lane strobes without lane enable give a read (R1)
    quiet(); ctl_n = 0; addr = 6'd9; lane_n = 4'b0000; tick();
    quiet(); tick();

    // linear and interleaved bursts from a misaligned start (R6), with a suspend (R7)
    for (int m = 0; m < 2; m++) begin
      deselect();
      @(negedge clk); lin = (m == 0);
      quiet(); cpu_n = 0; addr = 6'd22; tick();
      quiet(); step_n = 0; tick();
      quiet(); step_n = 1; tick();
      quiet(); step_n = 0; tick();
      quiet(); step_n = 0; tick();
      quiet(); tick();
    end

    // deselect by CPU strobe (R4) and ignored CPU strobe (R2)
    quiet(); cpu_n = 0; en_c = 0; tick();
    quiet(); step_n = 0; tick();
    quiet(); cpu_n = 0; en_a_n = 1; tick();
    quiet(); tick();
    quiet(); oe_n = 1; ctl_n = 0; addr = 6'd3; tick();
    quiet(); oe_n = 1; tick();

    // constrained random phases, order switched only while deselected
    for (int p = 0; p < 6; p++) begin
      deselect();
      @(negedge clk); lin = p[0];
      for (int i = 0; i < 1500; i++) random_cycle();
    end
    deselect();
    quiet(); tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule